// File: doc/BRIEF.md
# Transmit Holding Register Empty Interrupt Logic

This block produces the "transmitter ready for data" status bit and the matching interrupt for a 16550-style serial port with a 16-deep transmit FIFO. It watches the FIFO occupancy, the host's writes to the holding register and the host's reads of the interrupt identification register. From these it decides when the empty status may be shown and when an interrupt request is raised.

When the FIFO drains after carrying only one byte since the last empty indication, the empty status is held back. The hold lasts one character time minus the final stop bit, measured in 16x baud ticks. This gives the shift register time to send most of the byte before the host is asked for more. If the FIFO held two or more bytes at once in that interval, the status appears at once. The interrupt output also carries the identification code that the port's identification register shows when no receive interrupt outranks this one.

Top module: `thre_irq_top`

## Requirements
- R1: After reset the empty status `thre` is 1, `tx_irq` is 0 and `iir_code` is 4'h1.
- R2: Any clock edge that sees `tx_count` non-zero leaves `thre` at 0 after that edge.
- R3: With `fifo_en` = 1, if two or more bytes were in the FIFO together since `thre` last rose, `thre` rises on the first edge that sees `tx_count` = 0.
- R4: With `fifo_en` = 1 and at most one byte held since `thre` last rose, `thre` rises (`char_bits` − 1) × 16 baud ticks after the FIFO empties, plus one clock. `char_bits` counts start, data, parity and stop bits.
- R5: A holding-register write while the delay runs cancels it, and a later empty starts a fresh full delay.
- R6: With `fifo_en` = 0, `thre` rises on the first edge that sees `tx_count` = 0, with no delay.
- R7: When `fifo_en` and `tx_irq_en` are both 1, `tx_irq` rises one clock after `thre` rises.
- R8: `tx_irq` is 0 one clock after any edge where `fifo_en` or `tx_irq_en` is 0.
- R9: A holding-register write drops `tx_irq` on the next clock.
- R10: An identification read drops `tx_irq` on the next clock only when `iir_code` shows 4'h2 at that read. A read taken while `rx_pend` is 1 leaves `tx_irq` set.
- R11: `iir_code` is 4'h2 while `tx_irq` is 1 and `rx_pend` is 0; otherwise it is 4'h1 (no interrupt from this source).
- R12: A change of `fifo_en` to 1 while `thre` is 1 and `tx_irq_en` is 1 raises `tx_irq` on the next clock.
- R13: The "two or more bytes" record clears whenever `thre` rises, so a later single-byte burst is delayed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable from the FIFO control register |
| tx_irq_en | input | 1 | Transmit interrupt enable from the interrupt enable register |
| baud_tick | input | 1 | 16x baud-rate strobe, one clock wide |
| char_bits | input | 4 | Bits per character including start and stop bits |
| tx_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| thr_wr | input | 1 | Host write strobe to the holding register |
| iir_rd | input | 1 | Host read strobe of the identification register |
| rx_pend | input | 1 | A higher-priority receive interrupt is pending |
| thre | output | 1 | Holding register empty status bit |
| tx_irq | output | 1 | Transmit empty interrupt request |
| iir_code | output | 4 | Identification code from this source: 4'h2 or 4'h1 |

## Verification
The assertions take the FIFO count and the write strobe to be consistent: a write is followed by a non-zero count on the next clock, and the count never reaches two in the cycle the empty state is entered. The bench keeps to this by modelling the FIFO itself. It raises the count one clock after each write and walks it back down to zero one step per clock. It drives `baud_tick` high every clock, so the hold window is a plain clock count. All strobes and levels change on the falling edge.

// File: rtl/thre_pkg.sv
// Shared types and helpers for the transmit-empty interrupt logic.
// Assumes: character length is given in total bits on the line.
package thre_pkg;

    // Empty-status tracker states.
    typedef enum logic [1:0] {
        TX_EMPTY = 2'd0,   // status shown as empty
        TX_BUSY  = 2'd1,   // FIFO or holding register has data
        TX_HOLD  = 2'd2    // FIFO drained, empty status held back
    } tx_state_e;

    // Identification codes this source may present.
    localparam logic [3:0] ID_NONE = 4'h1;
    localparam logic [3:0] ID_THRE = 4'h2;

    // Hold length in ticks: one character less its final stop bit.
    function automatic int unsigned hold_ticks(input int unsigned bits,
                                               input int unsigned ovs);
        if (bits < 2)
            return 0;
        return (bits - 1) * ovs;
    endfunction

endpackage

// File: rtl/thre_multi_flag.sv
// Sticky record that the transmit FIFO held two or more bytes at once
// since the empty status last rose.
// Assumes: tx_count is below two whenever empty_rise pulses.
module thre_multi_flag #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             empty_rise,
    output logic             multi
);

    localparam logic [CNT_W-1:0] PAIR = CNT_W'(2);

    // Set on a pair seen, clear when the empty status rises.
    always_ff @(posedge clk) begin
        if (!rst_n)
            multi <= 1'b0;
        else if (empty_rise)
            multi <= 1'b0;
        else if (tx_count >= PAIR)
            multi <= 1'b1;
    end

endmodule

// File: rtl/thre_hold_timer.sv
// Down-counter that measures the held-back empty window in baud ticks.
// Assumes: load is a single-cycle pulse on entry to the hold state.
module thre_hold_timer #(
    parameter int CB_W = 4,
    parameter int OVS  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            run,
    input  logic            baud_tick,
    input  logic [CB_W-1:0] char_bits,
    output logic            done
);
    import thre_pkg::*;

    localparam int MAX_LEN = ((1 << CB_W) - 2) * OVS;
    localparam int TMR_W   = $clog2(MAX_LEN + 1);

    logic [TMR_W-1:0] remain;
    logic [TMR_W-1:0] load_val;

    // Window length for the current character format.
    always_comb begin
        load_val = TMR_W'(hold_ticks(32'(char_bits), OVS));
    end

    // Load on entry, count down once per tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (run && baud_tick && (remain != '0))
            remain <= remain - 1'b1;
    end

    // Window complete once the count is spent.
    always_comb begin
        done = (remain == '0);
    end

endmodule

// File: rtl/thre_status.sv
// Tracks whether the holding register may be reported empty. In FIFO
// mode a drain after a single byte is held back by the hold timer.
// Assumes: a write is followed by a non-zero tx_count on the next clock.
module thre_status #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             thr_wr,
    input  logic             multi,
    input  logic             tmr_done,
    output logic             thre,
    output logic             empty_rise,
    output logic             hold_load,
    output logic             hold_run
);
    import thre_pkg::*;

    tx_state_e state, state_nx;
    logic      has_data;

    // Data present in FIFO or arriving this cycle.
    always_comb begin
        has_data = thr_wr || (tx_count != '0);
    end

    // Next-state choice for the empty tracker.
    always_comb begin
        state_nx = state;
        unique case (state)
            TX_EMPTY: if (has_data) state_nx = TX_BUSY;
            TX_BUSY:  if (!has_data)
                          state_nx = (!fifo_en || multi) ? TX_EMPTY : TX_HOLD;
            TX_HOLD:  if (has_data)      state_nx = TX_BUSY;
                      else if (tmr_done) state_nx = TX_EMPTY;
            default:  state_nx = TX_EMPTY;
        endcase
    end

    // State register, empty after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= TX_EMPTY;
        else
            state <= state_nx;
    end

    // Decoded outputs and timer controls.
    always_comb begin
        thre       = (state == TX_EMPTY);
        empty_rise = (state != TX_EMPTY) && (state_nx == TX_EMPTY);
        hold_load  = (state != TX_HOLD) && (state_nx == TX_HOLD);
        hold_run   = (state == TX_HOLD);
    end

    assert_busy_clears_thre_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count != '0) |=> !thre);

    assert_pair_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_BUSY && tx_count == '0 && !thr_wr && multi && fifo_en) |=> thre);

    assert_hold_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_HOLD && !tmr_done) |=> !thre);

    assert_plain_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_BUSY && tx_count == '0 && !thr_wr && !fifo_en) |=> thre);

endmodule

// File: rtl/thre_irq_ctrl.sv
// Raises and clears the transmit-empty interrupt request and reports
// whether this source is the one the identification register shows.
// Assumes: rx_pend reflects all higher-priority receive sources.
module thre_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_en,
    input  logic tx_irq_en,
    input  logic thre,
    input  logic thr_wr,
    input  logic iir_rd,
    input  logic rx_pend,
    output logic tx_irq,
    output logic shown
);

    logic enabled;
    logic thre_d;
    logic fen_d;
    logic set_req;
    logic clr_req;

    // Enable and set/clear decode.
    always_comb begin
        enabled = fifo_en && tx_irq_en;
        shown   = tx_irq && !rx_pend;
        set_req = enabled && thre && (!thre_d || (fifo_en != fen_d));
        clr_req = !enabled || thr_wr || (iir_rd && shown);
    end

    // Edge-detect history for the status bit and FIFO enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thre_d <= 1'b1;
            fen_d  <= 1'b0;
        end else begin
            thre_d <= thre;
            fen_d  <= fifo_en;
        end
    end

    // Pending request, clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_irq <= 1'b0;
        else if (clr_req)
            tx_irq <= 1'b0;
        else if (set_req)
            tx_irq <= 1'b1;
    end

    assert_rise_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && tx_irq_en && $rose(thre) && !thr_wr && !iir_rd) |=> tx_irq);

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_en && tx_irq_en) |=> !tx_irq);

    assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !tx_irq);

endmodule

// File: rtl/thre_irq_top.sv
// Transmit holding register empty status and interrupt for a 16-deep
// transmit FIFO. Combines the pair record, the hold timer, the status
// tracker and the interrupt control, and forms the identification code.
// Assumes: baud_tick is a one-clock 16x strobe shared with the serializer.
module thre_irq_top #(
    parameter int DEPTH = 16,
    parameter int CB_W  = 4,
    parameter int OVS   = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             tx_irq_en,
    input  logic             baud_tick,
    input  logic [CB_W-1:0]  char_bits,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             rx_pend,
    output logic             thre,
    output logic             tx_irq,
    output logic [3:0]       iir_code
);
    import thre_pkg::*;

    logic multi;
    logic empty_rise;
    logic hold_load;
    logic hold_run;
    logic tmr_done;
    logic shown;

    thre_multi_flag #(.CNT_W(CNT_W)) u_multi (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_count   (tx_count),
        .empty_rise (empty_rise),
        .multi      (multi)
    );

    thre_hold_timer #(.CB_W(CB_W), .OVS(OVS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (hold_load),
        .run       (hold_run),
        .baud_tick (baud_tick),
        .char_bits (char_bits),
        .done      (tmr_done)
    );

    thre_status #(.CNT_W(CNT_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .tx_count   (tx_count),
        .thr_wr     (thr_wr),
        .multi      (multi),
        .tmr_done   (tmr_done),
        .thre       (thre),
        .empty_rise (empty_rise),
        .hold_load  (hold_load),
        .hold_run   (hold_run)
    );

    thre_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .tx_irq_en (tx_irq_en),
        .thre      (thre),
        .thr_wr    (thr_wr),
        .iir_rd    (iir_rd),
        .rx_pend   (rx_pend),
        .tx_irq    (tx_irq),
        .shown     (shown)
    );

    // Identification code from this source.
    always_comb begin
        iir_code = shown ? ID_THRE : ID_NONE;
    end

    assert_id_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_code == ID_THRE && !thr_wr) |=> !tx_irq);

    assert_code_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_code == ID_THRE) || (iir_code == ID_NONE));

endmodule

// File: tb/tb_thre_irq_top.sv
module tb_thre_irq_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_en, tx_irq_en, baud_tick, thr_wr, iir_rd, rx_pend;
    logic [3:0] char_bits;
    logic [4:0] tx_count;
    logic       thre, tx_irq;
    logic [3:0] iir_code;

    int total = 0;
    int fails = 0;
    int wd    = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;   // 125 MHz

    thre_irq_top dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_irq_en(tx_irq_en),
        .baud_tick(baud_tick), .char_bits(char_bits), .tx_count(tx_count),
        .thr_wr(thr_wr), .iir_rd(iir_rd), .rx_pend(rx_pend),
        .thre(thre), .tx_irq(tx_irq), .iir_code(iir_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count falling edges until thre is seen high.
    task automatic wait_thre(output int n);
        n = 0;
        while (!thre && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    // One byte: write, FIFO holds one, then drains.
    task automatic send_single();
        thr_wr = 1; cyc(1);
        thr_wr = 0; tx_count = 1; cyc(2);
        tx_count = 0;
    endtask

    // Two bytes held together, then drain.
    task automatic send_pair();
        thr_wr = 1; cyc(1);
        tx_count = 1; cyc(1);
        thr_wr = 0; tx_count = 2; cyc(1);
        tx_count = 1; cyc(1);
        tx_count = 0;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !done_flag) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int n;
        int len;
        rst_n = 0; fifo_en = 0; tx_irq_en = 0; baud_tick = 1; char_bits = 4'd10;
        tx_count = 0; thr_wr = 0; iir_rd = 0; rx_pend = 0;
        cyc(3);
        check(thre == 1, "R1 thre", thre, 1);
        check(tx_irq == 0, "R1 irq", tx_irq, 0);
        check(iir_code == 4'h1, "R1 code", iir_code, 1);
        rst_n = 1; cyc(1);

        // R6 plain mode: no delay; R2 busy clears thre
        thr_wr = 1; cyc(1);
        thr_wr = 0; tx_count = 1; cyc(1);
        check(thre == 0, "R2 busy", thre, 0);
        tx_count = 0;
        wait_thre(n);
        check(n == 1, "R6 plain drain", n, 1);
        cyc(1);
        check(tx_irq == 0, "R8 fifo off", tx_irq, 0);

        // R12 FIFO enable change with thre high
        fifo_en = 1; tx_irq_en = 1; cyc(1);
        check(tx_irq == 1, "R12 enable change", tx_irq, 1);
        check(iir_code == 4'h2, "R11 code shown", iir_code, 2);

        // R10 / R11 with receive pending
        rx_pend = 1; cyc(0);
        #1;
        check(iir_code == 4'h1, "R11 masked code", iir_code, 1);
        iir_rd = 1; cyc(1);
        iir_rd = 0; cyc(1);
        check(tx_irq == 1, "R10 masked read", tx_irq, 1);
        rx_pend = 0; iir_rd = 1; cyc(1);
        iir_rd = 0;
        check(tx_irq == 0, "R10 shown read", tx_irq, 0);
        check(iir_code == 4'h1, "R11 idle code", iir_code, 1);

        // R4 sweep over character lengths, R7 and R9 along the way
        for (int cb = 7; cb <= 12; cb++) begin
            char_bits = 4'(cb);
            len = (cb - 1) * 16;
            thr_wr = 1; cyc(1);
            thr_wr = 0; tx_count = 1;
            check(tx_irq == 0, "R9 write clears", tx_irq, 0);
            cyc(2);
            tx_count = 0;
            wait_thre(n);
            check(n == len + 2, "R4 hold length", n, len + 2);
            cyc(1);
            check(tx_irq == 1, "R7 irq after rise", tx_irq, 1);
        end

        // R3 pair seen: immediate
        char_bits = 4'd10; len = 9 * 16;
        send_pair();
        wait_thre(n);
        check(n == 1, "R3 pair immediate", n, 1);
        cyc(1);
        check(tx_irq == 1, "R7 irq after pair", tx_irq, 1);

        // R13 record cleared: single byte delayed again
        send_single();
        wait_thre(n);
        check(n == len + 2, "R13 delayed again", n, len + 2);

        // R5 write during hold cancels and restarts the window
        send_single();
        cyc(20);
        check(thre == 0, "R5 in hold", thre, 0);
        thr_wr = 1; cyc(1);
        thr_wr = 0; tx_count = 1; cyc(len);
        check(thre == 0, "R5 cancelled", thre, 0);
        tx_count = 0;
        wait_thre(n);
        check(n == len + 2, "R5 fresh window", n, len + 2);

        // R2 sweep every non-zero occupancy
        thr_wr = 1; cyc(1);
        thr_wr = 0;
        for (int c = 1; c <= 16; c++) begin
            tx_count = 5'(c); cyc(1);
            check(thre == 0, "R2 occupancy", thre, 0);
        end
        tx_count = 0;
        wait_thre(n);
        check(n == 1, "R3 after deep fill", n, 1);

        // R8 interrupt enable off
        tx_irq_en = 0;
        send_pair();
        wait_thre(n);
        cyc(2);
        check(tx_irq == 0, "R8 enable off", tx_irq, 0);
        check(iir_code == 4'h1, "R11 disabled code", iir_code, 1);

        done_flag = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule